// File: doc/BRIEF.md
# Compare/Capture Interval Timer

This peripheral keeps a 16-bit up-counter that advances on a count-enable tick, and watches it for three events: the counter wrapping past its top value, the counter arriving at a programmed compare value, and a level change on an external capture pin. A capture copies the counter into a holding register. Each event raises a sticky flag, and an interrupt request goes out when a flag and its enable bit are both set. The request carries a source code that names the winning event.

Software reaches the block over an 8-bit register bus with separate read and write strobes and a 3-bit address. A flag cannot be cleared by writing to it. Software must first read the status register while the flag is set, which arms that flag for clearing. The flag then clears on the next access to the data register that belongs to it. This stops an event that arrives between the status read and the data access from being lost. A capture input pin and a control bit together pick which edge causes a capture.

Top module: `cmpcap_timer`

## Requirements
- R1: After a synchronous reset the counter reads 0x0000, the compare register reads 0xFFFF, the capture register reads 0x0000, the status register reads 0x00, and all flags and the interrupt request are low.
- R2: The counter goes up by one, modulo 2^16, at each clock edge where `cnt_tick` is high, and holds otherwise. Address 1 reads its high byte and address 2 reads its low byte.
- R3: The overflow flag (status bit 5, output `ovf_flag`) sets at the edge where the counter wraps from 0xFFFF to 0x0000.
- R4: The compare flag (status bit 6, output `cmp_flag`) sets at the edge where the counter steps onto the value in the compare register. The compare register is written at address 3 (high byte) and address 4 (low byte).
- R5: A capture happens when `capt_pin` differs from its level in the previous cycle and its new level equals the edge-select bit (status bit 1). At the next edge the capture register loads the counter value of that cycle and the capture flag (status bit 7, output `capt_flag`) sets. A change to the other level has no effect. Address 5 reads the capture high byte and address 6 reads the low byte.
- R6: A flag clears only when the status register (address 0) was read while the flag was set, and a matching access follows. For overflow the access is a read of the counter high byte. For compare it is a write that changes either compare byte. For capture it is a read of the capture high byte. The same access made without that earlier status read leaves the flag set.
- R7: A status read arms only the flags that are set at that read. A flag that sets after the read is not cleared by the data access that follows.
- R8: A status write ANDs the armed state with written bits 7:5 (capture, compare, overflow). Writing 0 in a flag position disarms that flag. Status writes never change the flags themselves.
- R9: A write to a compare byte that already holds the written value leaves the compare register unchanged and does not clear an armed compare flag.
- R10: `irq_req` is high when any flag is set together with its enable. The enables are status bit 4 (capture), bit 3 (compare) and bit 2 (overflow). `irq_src` gives the pending source with the highest priority: 1 for capture, 2 for compare, 3 for overflow, and 0 when nothing is pending.
- R11: A status write stores bits 4:1 (the three enables and the edge select). A status read returns the flags in bits 7:5, those control bits in bits 4:1, and 0 in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| cnt_tick | input | 1 | Count enable for the current cycle |
| capt_pin | input | 1 | Capture input, already synchronous to clk |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare flag |
| capt_flag | output | 1 | Capture flag |
| irq_req | output | 1 | Interrupt request |
| irq_src | output | 2 | Source code of the pending interrupt with the highest priority |

## Verification
A wrong arming bit only becomes visible when software makes its next data access. At that point a flag stays set on the flag output when it should have dropped, or drops when it should have stayed. For that reason the bench puts every clearing access between probes of the flag outputs taken one cycle before and one cycle after the access. A fault in the counter or the compare match first shows when an event flag rises one or more ticks early or late. The bench therefore probes the flags on the tick just before each expected event and on the tick of the event. A priority fault shows on `irq_src` in the same cycle that the second flag rises.

// File: rtl/cmpcap_pkg.sv
// Package: shared register addresses, status bit positions, event indices
// and interrupt source codes for the compare/capture timer.
package cmpcap_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int NUM_EVT = 3;

    // register addresses
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd5;
    localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd6;

    // event indices into flag/enable vectors
    localparam int EV_OVF = 0;
    localparam int EV_CMP = 1;
    localparam int EV_CAP = 2;

    // status register bit positions: flags live at FLAG_LSB+event,
    // enables at EN_LSB+event
    localparam int FLAG_LSB = 5;
    localparam int EN_LSB   = 2;
    localparam int EDGE_BIT = 1;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CAPT = 2'd1,
        SRC_CMP  = 2'd2,
        SRC_OVF  = 2'd3
    } irq_src_e;

endpackage

// File: rtl/cmpcap_counter.sv
// Free-running counter with wrap and compare-match detection.
// Assumes cmp_val is stable in the cycle it is compared. Both hit pulses
// are combinational and refer to the edge at which the counter steps.
module cmpcap_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_hit,
    output logic             cmp_hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_nxt;

    // next count value when a tick arrives
    assign cnt_nxt = cnt + ONE;

    // event pulses for the flag unit
    assign ovf_hit = tick && (cnt == '1);
    assign cmp_hit = tick && (cnt_nxt == cmp_val);

    // counter register, advanced by the tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= cnt_nxt;
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> cnt == $past(cnt));                                   // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt == $past(cnt) + ONE);                              // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_hit |=> cnt == '0);                                         // R3
    AST_CMP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit |=> cnt == $past(cmp_val));                             // R4

endmodule

// File: rtl/cmpcap_capture.sv
// Edge-selectable capture: registers the pin level, detects a change to
// the level chosen by edge_sel, and snapshots the counter on that cycle.
// Assumes pin is already synchronous to clk.
module cmpcap_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             edge_sel,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_hit
);
    logic pin_q;

    // active edge: level changed and landed on the selected level
    assign cap_hit = (pin != pin_q) && (pin == edge_sel);

    // previous pin level
    always_ff @(posedge clk) begin
        if (!rst_n)
            pin_q <= 1'b0;
        else
            pin_q <= pin;
    end

    // capture holding register
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_val <= '0;
        else if (cap_hit)
            cap_val <= cnt;
    end

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_hit |=> $stable(cap_val));                                 // R5
    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> cap_val == $past(cnt));                             // R5

endmodule

// File: rtl/cmpcap_flags.sv
// Sticky event flags with the two-step clear handshake and the
// prioritised interrupt request. Assumes stat_rd, stat_wr and data_acc
// are single-cycle strobes from the bus decoder, never two at once.
module cmpcap_flags
    import cmpcap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_hit,
    input  logic [NUM_EVT-1:0] data_acc,
    input  logic               stat_rd,
    input  logic               stat_wr,
    input  logic [NUM_EVT-1:0] wr_mask,
    input  logic [NUM_EVT-1:0] en,
    output logic [NUM_EVT-1:0] flag,
    output logic               irq,
    output logic [1:0]         irq_src
);
    logic [NUM_EVT-1:0] armed;
    logic [NUM_EVT-1:0] pend;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        logic do_clr;

        // an armed flag clears on its matching data access
        assign do_clr = data_acc[g] && armed[g];

        // flag: a new event wins over a clear in the same cycle
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag[g] <= 1'b0;
            else if (evt_hit[g])
                flag[g] <= 1'b1;
            else if (do_clr)
                flag[g] <= 1'b0;
        end

        // arming state: set by a status read of a set flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                armed[g] <= 1'b0;
            else if (stat_wr)
                armed[g] <= armed[g] & wr_mask[g];
            else if (stat_rd)
                armed[g] <= armed[g] | flag[g];
            else if (do_clr)
                armed[g] <= 1'b0;
        end

        AST_CLR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag[g]) |-> $past(armed[g] && data_acc[g]));         // R6
        AST_SET_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[g]) |-> $past(evt_hit[g]));                      // R6
        AST_ARM_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(armed[g]) |-> $past(stat_rd && flag[g]));             // R7
        AST_WR_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_wr && !wr_mask[g]) |=> !armed[g]);                    // R8
    end

    assign pend = flag & en;
    assign irq  = |pend;

    // priority encoder: capture over compare over overflow
    always_comb begin
        if (pend[EV_CAP])
            irq_src = SRC_CAPT;
        else if (pend[EV_CMP])
            irq_src = SRC_CMP;
        else if (pend[EV_OVF])
            irq_src = SRC_OVF;
        else
            irq_src = SRC_NONE;
    end

    AST_PRIO_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
        (flag[EV_CAP] && en[EV_CAP]) |-> irq_src == SRC_CAPT);          // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src == SRC_NONE) |-> !irq);                                // R10

endmodule

// File: rtl/cmpcap_timer.sv
// Top: register bus decode, control/compare registers, read mux, and the
// wiring of counter, capture and flag units. Assumes bus_rd and bus_wr
// are never high together; read data is combinational from bus_addr.
module cmpcap_timer
    import cmpcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cnt_tick,
    input  logic              capt_pin,
    output logic              ovf_flag,
    output logic              cmp_flag,
    output logic              capt_flag,
    output logic              irq_req,
    output logic [1:0]        irq_src
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   cmp_val;
    logic [CNT_W-1:0]   cap_val;
    logic [NUM_EVT-1:0] en;
    logic               edge_sel;
    logic [NUM_EVT-1:0] evt_hit;
    logic [NUM_EVT-1:0] data_acc;
    logic [NUM_EVT-1:0] flag;
    logic               ovf_hit, cmp_hit, cap_hit;
    logic               wr_cmp_hi, wr_cmp_lo;
    logic               stat_rd, stat_wr;

    // bus strobes decoded per register
    assign stat_rd   = bus_rd && (bus_addr == A_STAT);
    assign stat_wr   = bus_wr && (bus_addr == A_STAT);
    assign wr_cmp_hi = bus_wr && (bus_addr == A_CMP_HI) && (bus_wdata != cmp_val[CNT_W-1:DATA_W]);
    assign wr_cmp_lo = bus_wr && (bus_addr == A_CMP_LO) && (bus_wdata != cmp_val[DATA_W-1:0]);

    // data accesses that complete a clear handshake
    assign data_acc[EV_OVF] = bus_rd && (bus_addr == A_CNT_HI);
    assign data_acc[EV_CMP] = wr_cmp_hi || wr_cmp_lo;
    assign data_acc[EV_CAP] = bus_rd && (bus_addr == A_CAP_HI);

    assign evt_hit[EV_OVF] = ovf_hit;
    assign evt_hit[EV_CMP] = cmp_hit;
    assign evt_hit[EV_CAP] = cap_hit;

    // control bits: enables and edge select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= '0;
            edge_sel <= 1'b0;
        end else if (stat_wr) begin
            en       <= bus_wdata[EN_LSB +: NUM_EVT];
            edge_sel <= bus_wdata[EDGE_BIT];
        end
    end

    // compare register, changed only by a differing byte
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_val <= '1;
        else if (wr_cmp_hi)
            cmp_val[CNT_W-1:DATA_W] <= bus_wdata;
        else if (wr_cmp_lo)
            cmp_val[DATA_W-1:0] <= bus_wdata;
    end

    // read data mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_STAT: begin
                bus_rdata[FLAG_LSB +: NUM_EVT] = flag;
                bus_rdata[EN_LSB +: NUM_EVT]   = en;
                bus_rdata[EDGE_BIT]            = edge_sel;
            end
            A_CNT_HI: bus_rdata = cnt[CNT_W-1:DATA_W];
            A_CNT_LO: bus_rdata = cnt[DATA_W-1:0];
            A_CMP_HI: bus_rdata = cmp_val[CNT_W-1:DATA_W];
            A_CMP_LO: bus_rdata = cmp_val[DATA_W-1:0];
            A_CAP_HI: bus_rdata = cap_val[CNT_W-1:DATA_W];
            A_CAP_LO: bus_rdata = cap_val[DATA_W-1:0];
            default:  bus_rdata = '0;
        endcase
    end

    cmpcap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (cnt_tick),
        .cmp_val (cmp_val),
        .cnt     (cnt),
        .ovf_hit (ovf_hit),
        .cmp_hit (cmp_hit)
    );

    cmpcap_capture #(.CNT_W(CNT_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (capt_pin),
        .edge_sel (edge_sel),
        .cnt      (cnt),
        .cap_val  (cap_val),
        .cap_hit  (cap_hit)
    );

    cmpcap_flags u_flg (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_hit  (evt_hit),
        .data_acc (data_acc),
        .stat_rd  (stat_rd),
        .stat_wr  (stat_wr),
        .wr_mask  (bus_wdata[FLAG_LSB +: NUM_EVT]),
        .en       (en),
        .flag     (flag),
        .irq      (irq_req),
        .irq_src  (irq_src)
    );

    assign ovf_flag  = flag[EV_OVF];
    assign cmp_flag  = flag[EV_CMP];
    assign capt_flag = flag[EV_CAP];

    AST_CMP_SAME_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CMP_LO && bus_wdata == cmp_val[DATA_W-1:0])
        |=> $stable(cmp_val));                                          // R9
    AST_CTL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> $stable(en) && $stable(edge_sel));                 // R11

endmodule

// File: tb/cmpcap_timer_tb_top.sv
`timescale 1ns/1ps
module cmpcap_timer_tb_top;

    localparam time TCK = 4ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cnt_tick = 1'b0;
    logic       capt_pin = 1'b0;
    logic       ovf_flag, cmp_flag, capt_flag, irq_req;
    logic [1:0] irq_src;
    logic       probe = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [15:0] mcnt = '0;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #(TCK/2) clk = ~clk;

    cmpcap_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_tick  (cnt_tick),
        .capt_pin  (capt_pin),
        .ovf_flag  (ovf_flag),
        .cmp_flag  (cmp_flag),
        .capt_flag (capt_flag),
        .irq_req   (irq_req),
        .irq_src   (irq_src)
    );

    // monitor: pops the expected item and compares mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (bus_rd || probe) begin
                logic [7:0] act;
                act = bus_rd ? bus_rdata
                             : {2'b00, capt_flag, cmp_flag, ovf_flag, irq_req, irq_src};
                n_chk++;
                if (sb_q.size() == 0) begin
                    n_err++;
                    $display("FAIL scoreboard empty: act=%02h exp=none", act);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (act !== e.val) begin
                        n_err++;
                        $display("FAIL %s: act=%02h exp=%02h", e.tag, act, e.val);
                    end
                end
            end
        end
    end

    task automatic drive(input logic rd, input logic wr, input logic [2:0] a,
                         input logic [7:0] d, input logic tk, input logic pb);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
        cnt_tick = tk; probe = pb;
        if (tk) mcnt = mcnt + 16'd1;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        it.val = e; it.tag = tag;
        sb_q.push_back(it);
        drive(1'b1, 1'b0, a, 8'h00, 1'b0, 1'b0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        drive(1'b0, 1'b1, a, d, 1'b0, 1'b0);
    endtask

    // expected vector: {cap, cmp, ovf, irq, src[1:0]}
    task automatic pb(input logic [5:0] e, input string tag);
        exp_t it;
        it.val = {2'b00, e}; it.tag = tag;
        sb_q.push_back(it);
        drive(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic idle(input int n, input logic tk);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 3'd0, 8'h00, tk, 1'b0);
    endtask

    task automatic setpin(input logic v);
        @(negedge clk);
        capt_pin = v;
        bus_rd = 1'b0; bus_wr = 1'b0; cnt_tick = 1'b0; probe = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        #(TCK * 200000);
        n_chk++; n_err++;
        $display("FAIL watchdog: act=running exp=finished");
        finish_run();
    end

    initial begin
        idle(4, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        pb(6'b000000, "R1 flags/irq");
        rd(3'd0, 8'h00, "R1 status");
        rd(3'd3, 8'hFF, "R1 cmp hi");
        rd(3'd4, 8'hFF, "R1 cmp lo");
        rd(3'd1, 8'h00, "R1 cnt hi");
        rd(3'd2, 8'h00, "R1 cnt lo");
        rd(3'd5, 8'h00, "R1 cap hi");
        rd(3'd6, 8'h00, "R1 cap lo");

        // R2 counting with and without tick
        idle(5, 1'b1);
        rd(3'd2, mcnt[7:0], "R2 cnt lo after ticks");
        idle(3, 1'b0);
        rd(3'd2, 8'h05, "R2 cnt lo holds");
        rd(3'd1, 8'h00, "R2 cnt hi");

        // R11 control bits
        wr(3'd0, 8'h02);
        rd(3'd0, 8'h02, "R11 edge select readback");

        // R5 rising capture at count 5
        setpin(1'b1);
        pb(6'b100000, "R5 capture flag");
        rd(3'd6, 8'h05, "R5 capture lo");
        rd(3'd5, 8'h00, "R6 cap hi read unarmed");
        pb(6'b100000, "R6 capture flag kept");
        idle(2, 1'b1);
        setpin(1'b0);
        rd(3'd6, 8'h05, "R5 falling edge ignored");
        rd(3'd0, 8'h82, "R6 status arm capture");
        rd(3'd5, 8'h00, "R6 cap hi clears");
        pb(6'b000000, "R6 capture cleared");
        rd(3'd0, 8'h02, "R6 status after clear");

        // R4 compare at 0x0020
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h20);
        rd(3'd3, 8'h00, "R4 cmp hi");
        rd(3'd4, 8'h20, "R4 cmp lo");
        idle(32'h1F - int'(mcnt), 1'b1);
        pb(6'b000000, "R4 no match one tick early");
        idle(1, 1'b1);
        pb(6'b010000, "R4 compare flag");
        rd(3'd0, 8'h42, "R4 status arms compare");

        // R9 same-value write
        wr(3'd4, 8'h20);
        pb(6'b010000, "R9 same value keeps flag");
        rd(3'd4, 8'h20, "R9 cmp lo unchanged");
        wr(3'd4, 8'h40);
        pb(6'b000000, "R6 changed write clears");

        // R7 flag set after the status read is not armed
        rd(3'd0, 8'h02, "R7 status nothing set");
        idle(32'h40 - int'(mcnt), 1'b1);
        pb(6'b010000, "R7 compare at 0x40");
        wr(3'd4, 8'h41);
        pb(6'b010000, "R7 unarmed write keeps flag");
        rd(3'd4, 8'h41, "R7 cmp lo written");

        // R8 status write masks arming
        rd(3'd0, 8'h42, "R8 arm compare");
        wr(3'd0, 8'h02);
        wr(3'd4, 8'h50);
        pb(6'b010000, "R8 disarmed by status write");
        rd(3'd0, 8'h42, "R8 re-arm");
        wr(3'd0, 8'h42);
        rd(3'd0, 8'h42, "R8 flag untouched by write");
        wr(3'd4, 8'h60);
        pb(6'b000000, "R8 arm kept by mask bit");

        // R10 enables and priority
        wr(3'd0, 8'h1A);
        rd(3'd0, 8'h1A, "R11 enables readback");
        idle(32'h60 - int'(mcnt), 1'b1);
        pb(6'b010110, "R10 compare irq src 2");
        setpin(1'b1);
        pb(6'b110101, "R10 capture wins src 1");
        rd(3'd6, 8'h60, "R5 capture at 0x60");
        rd(3'd0, 8'hDA, "R10 status both flags");
        rd(3'd5, 8'h00, "R6 cap hi clear");
        pb(6'b010110, "R10 back to compare");
        wr(3'd0, 8'h12);
        pb(6'b010000, "R10 compare disabled");

        // R3 overflow
        wr(3'd0, 8'h04);
        idle(32'hFFFF - int'(mcnt), 1'b1);
        pb(6'b010000, "R3 no overflow at 0xFFFF");
        rd(3'd1, 8'hFF, "R2 cnt hi top");
        rd(3'd2, 8'hFF, "R2 cnt lo top");
        idle(1, 1'b1);
        pb(6'b011111, "R3 overflow flag src 3");
        rd(3'd1, 8'h00, "R6 cnt hi read unarmed");
        pb(6'b011111, "R6 overflow kept");
        rd(3'd0, 8'h64, "R3 status arm overflow");
        rd(3'd1, 8'h00, "R6 cnt hi clears");
        pb(6'b010000, "R6 overflow cleared");

        idle(2, 1'b0);
        if (sb_q.size() != 0) begin
            n_chk++; n_err++;
            $display("FAIL scoreboard leftover: act=%0d exp=0", sb_q.size());
        end
        finish_run();
    end

endmodule